// File: doc/BRIEF.md
# SPI Receive Word Match Unit

This unit watches the stream of words that an SPI controller's shifter delivers and tests each one against two programmable reference values. A three-bit rule selector chooses how the test is made: against the first word of a frame only or against every word, for equality with either reference, for an ordered pair of words, or for equality under a bit mask taken from the second reference. When the selected rule is satisfied, a sticky match flag is set. Software clears the flag by writing a one to it.

The unit also decides, for each received word, whether the word goes into the receive FIFO. A filtering control can discard all incoming words until a match has been seen. An interrupt request is raised while the flag is set and its enable bit is high. The serial shifter, the FIFO storage and the register bus are outside this block. Only the strobes and fields those parts exchange with it appear as ports.

Top module: `spi_rx_match`

## Requirements
- R1: After reset `match_flag` is 0 and `irq` is 0.
- R2: With `rule` equal to 0 (off) or 1 (reserved), no received word ever sets `match_flag`.
- R3: With `rule` = 2, the flag is set when the frame's first word (the one presented with `word_sof` = 1) equals `ref_a` or `ref_b`. A later word of the frame that equals either reference does not set it.
- R4: With `rule` = 3, any word of a frame that equals `ref_a` or `ref_b` sets the flag.
- R5: With `rule` = 4, the flag is set only when the first word equals `ref_a` and the very next word equals `ref_b`.
- R6: With `rule` = 5, the flag is set when a word equals `ref_b` and the word just before it in the same frame equals `ref_a`. A word carrying `word_sof` = 1 never completes a pair that was started in the previous frame.
- R7: With `rule` = 6, the flag is set when `(first word & ref_b) == (ref_a & ref_b)`. A later word that meets this test does not set it.
- R8: With `rule` = 7, the masked test of R7 applies to every word.
- R9: `match_flag` rises one clock after the matching word strobe. It stays set while `flag_clr` is 0. A `flag_clr` pulse clears it one clock later. If a matching word and `flag_clr` arrive in the same cycle, the flag stays set.
- R10: `irq` is 1 exactly when `match_flag` is 1 and `irq_en` is 1.
- R11: `store_word` is a combinational decision that can only be 1 in a cycle where `word_vld` is 1. With `match_only` = 0, every word is stored. With `match_only` = 1, words are discarded while the flag is clear. The word that causes the match is stored, and so is every word after it while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | Received word strobe, one cycle per word |
| word_data | input | DATA_W | Received word |
| word_sof | input | 1 | Marks the first word after chip select asserts |
| rule | input | 3 | Compare rule selector (0..7) |
| ref_a | input | DATA_W | First reference value |
| ref_b | input | DATA_W | Second reference value / mask |
| match_only | input | 1 | Discard words until a match is flagged |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt enable |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| store_word | output | 1 | Push the current word into the receive FIFO |

## Verification
The set path and the clear path of the sticky flag can be active in the same cycle. The bench provokes this by holding `flag_clr` high during the strobe of a word that satisfies the active rule. It then checks that the flag reads 1 on the following cycle. A second case covers the store decision: a word can complete a match while filtering is on. The bench checks that this word is stored even though the flag was still clear when it arrived.

// File: rtl/spi_rx_match_pkg.sv
package spi_rx_match_pkg;

    typedef enum logic [2:0] {
        RULE_OFF        = 3'd0,
        RULE_RSVD       = 3'd1,
        RULE_FIRST_ANY  = 3'd2,
        RULE_EACH_ANY   = 3'd3,
        RULE_FIRST_PAIR = 3'd4,
        RULE_EACH_PAIR  = 3'd5,
        RULE_FIRST_MASK = 3'd6,
        RULE_EACH_MASK  = 3'd7
    } rule_e;

    typedef struct packed {
        logic flag;        // sticky match flag
        logic prev_a;      // previous word of this frame equalled ref_a
        logic prev_first;  // previous word was the frame's first word
    } match_state_t;

endpackage

// File: rtl/spi_rxm_compare.sv
module spi_rxm_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] ref_a,
    input  logic [DATA_W-1:0] ref_b,
    output logic              eq_a,
    output logic              eq_b,
    output logic              eq_mask
);
    always_comb begin
        eq_a    = (data == ref_a);
        eq_b    = (data == ref_b);
        eq_mask = ((data & ref_b) == (ref_a & ref_b));
    end
endmodule

// File: rtl/spi_rxm_rule.sv
module spi_rxm_rule
    import spi_rx_match_pkg::*;
(
    input  logic [2:0] rule,
    input  logic       sof,
    input  logic       eq_a,
    input  logic       eq_b,
    input  logic       eq_mask,
    input  logic       prev_a,
    input  logic       prev_first,
    output logic       hit
);
    logic pair_ok;

    always_comb begin
        // a pair never crosses a frame start
        pair_ok = !sof && prev_a && eq_b;
        unique case (rule_e'(rule))
            RULE_FIRST_ANY:  hit = sof && (eq_a || eq_b);
            RULE_EACH_ANY:   hit = eq_a || eq_b;
            RULE_FIRST_PAIR: hit = pair_ok && prev_first;
            RULE_EACH_PAIR:  hit = pair_ok;
            RULE_FIRST_MASK: hit = sof && eq_mask;
            RULE_EACH_MASK:  hit = eq_mask;
            default:         hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_rx_match.sv
module spi_rx_match
    import spi_rx_match_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_sof,
    input  logic [2:0]        rule,
    input  logic [DATA_W-1:0] ref_a,
    input  logic [DATA_W-1:0] ref_b,
    input  logic              match_only,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              match_flag,
    output logic              irq,
    output logic              store_word
);
    match_state_t st_d, st_q;
    logic eq_a, eq_b, eq_mask, hit_raw, hit;

    spi_rxm_compare #(.DATA_W(DATA_W)) u_cmp (
        .data    (word_data),
        .ref_a   (ref_a),
        .ref_b   (ref_b),
        .eq_a    (eq_a),
        .eq_b    (eq_b),
        .eq_mask (eq_mask)
    );

    spi_rxm_rule u_rule (
        .rule       (rule),
        .sof        (word_sof),
        .eq_a       (eq_a),
        .eq_b       (eq_b),
        .eq_mask    (eq_mask),
        .prev_a     (st_q.prev_a),
        .prev_first (st_q.prev_first),
        .hit        (hit_raw)
    );

    always_comb begin
        hit  = word_vld && hit_raw;
        st_d = st_q;
        // set has priority over the write-one clear
        st_d.flag = (st_q.flag && !flag_clr) || hit;
        if (word_vld) begin
            st_d.prev_a     = eq_a;
            st_d.prev_first = word_sof;
        end
        match_flag = st_q.flag;
        irq        = st_q.flag && irq_en;
        store_word = word_vld && (!match_only || st_q.flag || hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_rx_match_chk.sv
module spi_rx_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       word_vld,
    input logic [2:0] rule,
    input logic       match_only,
    input logic       flag_clr,
    input logic       irq_en,
    input logic       match_flag,
    input logic       irq,
    input logic       store_word
);
    assert_off_rules_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rule < 3'd2 && !match_flag) |=> !match_flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag);

    assert_flag_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !word_vld) |=> !match_flag);

    assert_no_flag_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && irq_en));

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && irq_en) |-> irq);

    assert_store_needs_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> !store_word);

    assert_store_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !match_only) |-> store_word);
endmodule

bind spi_rx_match spi_rx_match_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .rule       (rule),
    .match_only (match_only),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .match_flag (match_flag),
    .irq        (irq),
    .store_word (store_word)
);

// File: tb/spi_rx_match_bench.sv
module spi_rx_match_bench;
    localparam int DW = 32;
    localparam logic [DW-1:0] VA = 32'hA5A5_0001;
    localparam logic [DW-1:0] VB = 32'h5A5A_0002;
    localparam logic [DW-1:0] VX = 32'h0000_0777;
    localparam logic [DW-1:0] MA = 32'hABCD_1234;
    localparam logic [DW-1:0] MB = 32'hFFFF_0000;
    localparam logic [DW-1:0] MW = 32'hABCD_9999;

    logic clk = 0, rst_n = 0;
    logic word_vld = 0, word_sof = 0, match_only = 0, flag_clr = 0, irq_en = 0;
    logic [DW-1:0] word_data = '0, ref_a = VA, ref_b = VB;
    logic [2:0] rule = 3'd0;
    logic match_flag, irq, store_word;
    logic last_store;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    spi_rx_match #(.DATA_W(DW)) u_spi_rx_match (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
        .word_sof(word_sof), .rule(rule), .ref_a(ref_a), .ref_b(ref_b),
        .match_only(match_only), .flag_clr(flag_clr), .irq_en(irq_en),
        .match_flag(match_flag), .irq(irq), .store_word(store_word)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send(input logic [DW-1:0] d, input logic sof);
        @(negedge clk);
        word_vld = 1; word_data = d; word_sof = sof;
        #1 last_store = store_word;
        @(negedge clk);
        word_vld = 0; word_sof = 0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 flag", match_flag, 1'b0);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_off();
        rule = 3'd0; send(VA, 1); send(VB, 0);
        check("R2 rule0", match_flag, 1'b0);
        rule = 3'd1; send(VA, 1); send(VA, 0);
        check("R2 rule1", match_flag, 1'b0);
    endtask

    task automatic t_first_any();
        rule = 3'd2; send(VX, 1); send(VA, 0);
        check("R3 later word ignored", match_flag, 1'b0);
        send(VB, 1);
        check("R3 first word hit", match_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_each_any();
        rule = 3'd3; send(VX, 1); send(VX, 0); send(VB, 0);
        check("R4 any word hit", match_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_first_pair();
        rule = 3'd4; send(VA, 1); send(VX, 0); send(VB, 0);
        check("R5 gap breaks pair", match_flag, 1'b0);
        send(VA, 1); send(VB, 0);
        check("R5 first pair hit", match_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_each_pair();
        rule = 3'd5; send(VX, 1); send(VA, 0); send(VB, 1);
        check("R6 no pair across frames", match_flag, 1'b0);
        send(VX, 0); send(VA, 0); send(VB, 0);
        check("R6 mid-frame pair hit", match_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_mask();
        ref_a = MA; ref_b = MB;
        rule = 3'd6; send(VX, 1); send(MW, 0);
        check("R7 later masked ignored", match_flag, 1'b0);
        send(MW, 1);
        check("R7 first masked hit", match_flag, 1'b1);
        clear_flag();
        rule = 3'd7; send(VX, 1); send(MW, 0);
        check("R8 any masked hit", match_flag, 1'b1);
        clear_flag();
        ref_a = VA; ref_b = VB;
    endtask

    task automatic t_sticky();
        rule = 3'd3; send(VA, 1);
        repeat (3) @(negedge clk);
        check("R9 sticky", match_flag, 1'b1);
        irq_en = 0; #1 check("R10 masked irq", irq, 1'b0);
        irq_en = 1; #1 check("R10 irq", irq, 1'b1);
        clear_flag();
        check("R9 cleared", match_flag, 1'b0);
        check("R10 irq drops", irq, 1'b0);
        @(negedge clk);
        word_vld = 1; word_data = VB; word_sof = 0; flag_clr = 1;
        @(negedge clk);
        word_vld = 0; flag_clr = 0;
        check("R9 set beats clear", match_flag, 1'b1);
        clear_flag(); irq_en = 0;
    endtask

    task automatic t_store();
        rule = 3'd0; match_only = 0;
        send(VX, 1); check("R11 store all", last_store, 1'b1);
        rule = 3'd3; match_only = 1;
        send(VX, 1); check("R11 discard", last_store, 1'b0);
        send(VA, 0); check("R11 matching word stored", last_store, 1'b1);
        send(VX, 0); check("R11 stored after match", last_store, 1'b1);
        @(negedge clk); #1 check("R11 idle no store", store_word, 1'b0);
        clear_flag(); match_only = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_off();
        t_first_any();
        t_each_any();
        t_first_pair();
        t_each_pair();
        t_mask();
        t_sticky();
        t_store();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule